// File: doc/BRIEF.md
# Card supply enable controller

This block is the digital control for the converter that powers a smart card. Software writes a control word that holds an enable bit, a two-bit supply level, a pump/regulator mode bit and a four-bit clock prescaler. The block turns these into a converter enable, a frozen level code, a mode signal and a divided converter clock. A raw card-presence input is synchronized and debounced before the block uses it.

The converter cannot start while no card is detected. If the card is removed or the analog side reports overcurrent while the converter runs, the block enters a timed discharge phase on its own and clears the enable bit. Software must then write the enable bit again. A software write that clears the enable bit uses the same discharge phase. A power-down request that arrives while the converter is not fully off is flagged.

Top module: `card_supply_ctrl`

## Requirements
- R1: After reset, convEn, shutBusy, rdEnable, ovcFlag and pwrDownErr are 0, convLevel is 0 and convMode is 0. The prescaler field is 0, so convClk toggles on every clock (divide by two).
- R2: When cfgWr is high with cfgEn=1 and the debounced card presence is high, rdEnable goes to 1 at the next edge and convEn goes to 1 at the edge after that.
- R3: While the debounced card presence is low, convEn stays 0 even though rdEnable reads 1.
- R4: cardRaw passes through two synchronizer flops and then has to stay at its new value for DEB_LEN consecutive clocks before it takes effect. A new level therefore acts at edge 2+DEB_LEN after it is applied, and a pulse shorter than DEB_LEN clocks is ignored.
- R5: When the debounced presence falls while convEn=1, convEn drops and shutBusy rises at the next edge, and rdEnable is cleared at that same edge. shutBusy stays high for exactly DIS_LEN clocks, and then the block is off.
- R6: An overCurr pulse while convEn=1 is registered once and then triggers the shutdown of R5 one edge later. That same edge sets ovcFlag, which stays 1 until a write with cfgEn=1.
- R7: While shutBusy=1, enable writes have no effect and rdEnable stays 0. After an automatic shutdown the converter stays off, even with the card present, until the enable bit is written to 1 again.
- R8: A write with cfgEn=0 while convEn=1 clears rdEnable at the next edge. It starts the same DIS_LEN-clock discharge one edge later and leaves ovcFlag unchanged.
- R9: While the block is off, convLevel and convMode follow the written level and mode fields two edges after the write. While convEn or shutBusy is high, they hold the values captured when the converter started.
- R10: convClk toggles every p+1 clocks, where p is the written prescaler field.
- R11: pwrDownErr is 1 one edge after pwrDownReq is sampled high while convEn or shutBusy is 1. It is 0 when the request comes while the block is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardRaw | input | 1 | Raw card-presence level, 1 = card inserted |
| overCurr | input | 1 | Overcurrent report from the analog side |
| pwrDownReq | input | 1 | Device power-down request |
| cfgWr | input | 1 | Write strobe for the control word |
| cfgEn | input | 1 | Enable bit of the control word |
| cfgLevel | input | LEVEL_W | Supply level field |
| cfgMode | input | 1 | Mode field, 1 = pump, 0 = regulator |
| cfgPresc | input | PRESC_W | Prescaler field |
| convEn | output | 1 | Converter enable |
| convLevel | output | LEVEL_W | Level code to the converter |
| convMode | output | 1 | Mode to the converter |
| convClk | output | 1 | Divided converter clock |
| shutBusy | output | 1 | Discharge phase in progress |
| rdEnable | output | 1 | Readback of the enable bit |
| ovcFlag | output | 1 | Sticky overcurrent status |
| pwrDownErr | output | 1 | Power-down request while the converter is not off |

## Verification
Every result has a fixed latency from its stimulus:
- rdEnable, ovcFlag and pwrDownErr are due one edge after the driving cycle.
- convEn and the captured level/mode are due two edges after a write.
- A change on cardRaw reaches convEn 3+DEB_LEN edges later, and shutBusy falls DIS_LEN edges after it rises.

Each stimulus task queues its expected values tagged with the exact cycle they are due. A monitor samples on the falling edge and compares only the items due in that cycle. Quiet windows are queued as several expected items, so that "stays low" is checked in more than one cycle.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_DRAIN = 2'd2
  } supState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrEnable;   // hardware clears the enable bit
    logic blockWrite;  // enable writes are ignored
    logic loadDrain;   // start the discharge timer
    logic setSticky;   // record an overcurrent event
    logic trackCfg;    // outputs follow the written level/mode
  } ctrlStrobe_t;

endpackage

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int DEB_LEN     = 4,
  parameter int DIS_LEN     = 8,
  parameter int PRESC_W     = 4,
  parameter int LEVEL_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cardRaw,
  input  logic               overCurr,
  input  logic               cfgWr,
  input  logic               cfgEn,
  input  logic [LEVEL_W-1:0] cfgLevel,
  input  logic               cfgMode,
  input  logic [PRESC_W-1:0] cfgPresc,
  input  ctrlStrobe_t        stb,
  output logic               presOk,
  output logic               ovcSeen,
  output logic               enBit,
  output logic               drainDone,
  output logic               ovcFlag,
  output logic [LEVEL_W-1:0] convLevel,
  output logic               convMode,
  output logic               convClk
);

  localparam int DCNT_W = $clog2(DEB_LEN + 1);
  localparam int DRN_W  = $clog2(DIS_LEN + 1);
  localparam logic [DCNT_W-1:0] DEB_LAST   = DCNT_W'(DEB_LEN - 1);
  localparam logic [DRN_W-1:0]  DRAIN_LAST = DRN_W'(DIS_LEN - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic [DCNT_W-1:0]      debCnt;
  logic [DRN_W-1:0]       drainCnt;
  logic [PRESC_W-1:0]     prescReg;
  logic [PRESC_W-1:0]     divCnt;
  logic [LEVEL_W-1:0]     levelReg;
  logic                   modeReg;

  assign syncOut   = syncChain[SYNC_STAGES-1];
  assign drainDone = (drainCnt == '0);

  // presence synchronizer and debounce
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      debCnt    <= '0;
      presOk    <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], cardRaw};
      if (syncOut == presOk) begin
        debCnt <= '0;
      end else if (debCnt == DEB_LAST) begin
        presOk <= syncOut;
        debCnt <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  // control word and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovcSeen  <= 1'b0;
      enBit    <= 1'b0;
      ovcFlag  <= 1'b0;
      prescReg <= '0;
      levelReg <= '0;
      modeReg  <= 1'b0;
    end else begin
      ovcSeen <= overCurr;
      if (stb.clrEnable) begin
        enBit <= 1'b0;
      end else if (cfgWr && !stb.blockWrite) begin
        enBit <= cfgEn;
      end
      if (stb.setSticky) begin
        ovcFlag <= 1'b1;
      end else if (cfgWr && cfgEn) begin
        ovcFlag <= 1'b0;
      end
      if (cfgWr) begin
        prescReg <= cfgPresc;
        levelReg <= cfgLevel;
        modeReg  <= cfgMode;
      end
    end
  end

  // level/mode outputs, frozen while the converter is active
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convLevel <= '0;
      convMode  <= 1'b0;
    end else if (stb.trackCfg) begin
      convLevel <= levelReg;
      convMode  <= modeReg;
    end
  end

  // discharge timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drainCnt <= '0;
    end else if (stb.loadDrain) begin
      drainCnt <= DRAIN_LAST;
    end else if (drainCnt != '0) begin
      drainCnt <= drainCnt - 1'b1;
    end
  end

  // converter clock divider: half period of prescReg+1 clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      convClk <= 1'b0;
    end else if (divCnt >= prescReg) begin
      divCnt  <= '0;
      convClk <= ~convClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        presOk,
  input  logic        ovcSeen,
  input  logic        enBit,
  input  logic        drainDone,
  input  logic        pwrDownReq,
  output ctrlStrobe_t stb,
  output logic        convEn,
  output logic        shutBusy,
  output logic        pwrDownErr
);

  supState_e state, stateNext;
  logic      autoTrip;

  assign autoTrip = !presOk || ovcSeen;
  assign convEn   = (state == ST_ON);
  assign shutBusy = (state == ST_DRAIN);

  always_comb begin
    stateNext      = state;
    stb            = '0;
    stb.trackCfg   = (state == ST_OFF);
    stb.blockWrite = (state == ST_DRAIN);
    unique case (state)
      ST_OFF: begin
        if (enBit && presOk) stateNext = ST_ON;
      end
      ST_ON: begin
        if (autoTrip || !enBit) begin
          stateNext     = ST_DRAIN;
          stb.loadDrain = 1'b1;
          stb.clrEnable = autoTrip;
        end
        stb.setSticky = ovcSeen;
      end
      ST_DRAIN: begin
        if (drainDone) stateNext = ST_OFF;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OFF;
      pwrDownErr <= 1'b0;
    end else begin
      state      <= stateNext;
      pwrDownErr <= pwrDownReq && (state != ST_OFF);
    end
  end

endmodule

// File: rtl/card_supply_ctrl.sv
module card_supply_ctrl
  import csc_pkg::*;
#(
  parameter int DEB_LEN = 4,
  parameter int DIS_LEN = 8,
  parameter int PRESC_W = 4,
  parameter int LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cardRaw,
  input  logic               overCurr,
  input  logic               pwrDownReq,
  input  logic               cfgWr,
  input  logic               cfgEn,
  input  logic [LEVEL_W-1:0] cfgLevel,
  input  logic               cfgMode,
  input  logic [PRESC_W-1:0] cfgPresc,
  output logic               convEn,
  output logic [LEVEL_W-1:0] convLevel,
  output logic               convMode,
  output logic               convClk,
  output logic               shutBusy,
  output logic               rdEnable,
  output logic               ovcFlag,
  output logic               pwrDownErr
);

  ctrlStrobe_t stb;
  logic        presOk;
  logic        ovcSeen;
  logic        drainDone;

  csc_datapath #(
    .DEB_LEN (DEB_LEN),
    .DIS_LEN (DIS_LEN),
    .PRESC_W (PRESC_W),
    .LEVEL_W (LEVEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cardRaw   (cardRaw),
    .overCurr  (overCurr),
    .cfgWr     (cfgWr),
    .cfgEn     (cfgEn),
    .cfgLevel  (cfgLevel),
    .cfgMode   (cfgMode),
    .cfgPresc  (cfgPresc),
    .stb       (stb),
    .presOk    (presOk),
    .ovcSeen   (ovcSeen),
    .enBit     (rdEnable),
    .drainDone (drainDone),
    .ovcFlag   (ovcFlag),
    .convLevel (convLevel),
    .convMode  (convMode),
    .convClk   (convClk)
  );

  csc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .presOk     (presOk),
    .ovcSeen    (ovcSeen),
    .enBit      (rdEnable),
    .drainDone  (drainDone),
    .pwrDownReq (pwrDownReq),
    .stb        (stb),
    .convEn     (convEn),
    .shutBusy   (shutBusy),
    .pwrDownErr (pwrDownErr)
  );

endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int LEVEL_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               convEn,
  input logic               shutBusy,
  input logic               rdEnable,
  input logic               ovcFlag,
  input logic               pwrDownReq,
  input logic               pwrDownErr,
  input logic [LEVEL_W-1:0] convLevel,
  input logic               presOk,
  input logic               ovcSeen
);

  // R5
  excl_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(convEn && shutBusy));

  // R2
  en_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convEn) |-> $past(rdEnable));

  // R3
  pres_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convEn) |-> $past(presOk));

  // R5
  loss_shut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convEn && !presOk) |=> (shutBusy && !rdEnable));

  // R6
  ovc_shut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convEn && ovcSeen) |=> (shutBusy && ovcFlag && !rdEnable));

  // R7
  drain_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutBusy |-> !rdEnable);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convEn && $past(convEn)) |-> $stable(convLevel));

  // R11
  pd_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownErr |-> ($past(pwrDownReq) && ($past(convEn) || $past(shutBusy))));

endmodule

bind card_supply_ctrl csc_checker #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .convEn     (convEn),
  .shutBusy   (shutBusy),
  .rdEnable   (rdEnable),
  .ovcFlag    (ovcFlag),
  .pwrDownReq (pwrDownReq),
  .pwrDownErr (pwrDownErr),
  .convLevel  (convLevel),
  .presOk     (presOk),
  .ovcSeen    (ovcSeen)
);

// File: tb/sim_card_supply_ctrl.sv
`timescale 1ns/1ps
module sim_card_supply_ctrl;

  localparam int DEB_LEN = 4;
  localparam int DIS_LEN = 8;

  // output selectors for expected items
  localparam int S_EN = 0, S_BUSY = 1, S_RDEN = 2, S_OVC = 3,
                 S_PDE = 4, S_LVL = 5, S_MODE = 6;

  typedef struct {
    int    due;
    int    sel;
    int    val;
    string req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cardRaw = 1'b0, overCurr = 1'b0, pwrDownReq = 1'b0;
  logic       cfgWr = 1'b0, cfgEn = 1'b0, cfgMode = 1'b0;
  logic [1:0] cfgLevel = '0;
  logic [3:0] cfgPresc = '0;
  logic       convEn, convMode, convClk, shutBusy, rdEnable, ovcFlag, pwrDownErr;
  logic [1:0] convLevel;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  card_supply_ctrl #(.DEB_LEN(DEB_LEN), .DIS_LEN(DIS_LEN)) u0 (
    .clk(clk), .rstN(rstN), .cardRaw(cardRaw), .overCurr(overCurr),
    .pwrDownReq(pwrDownReq), .cfgWr(cfgWr), .cfgEn(cfgEn),
    .cfgLevel(cfgLevel), .cfgMode(cfgMode), .cfgPresc(cfgPresc),
    .convEn(convEn), .convLevel(convLevel), .convMode(convMode),
    .convClk(convClk), .shutBusy(shutBusy), .rdEnable(rdEnable),
    .ovcFlag(ovcFlag), .pwrDownErr(pwrDownErr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pick(int sel);
    case (sel)
      S_EN:    return int'(convEn);
      S_BUSY:  return int'(shutBusy);
      S_RDEN:  return int'(rdEnable);
      S_OVC:   return int'(ovcFlag);
      S_PDE:   return int'(pwrDownErr);
      S_LVL:   return int'(convLevel);
      default: return int'(convMode);
    endcase
  endfunction

  task automatic check(string req, string what, int got, int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic expectAt(int sel, int val, int lat, string req);
    expItem_t it;
    it.due = cyc + lat;
    it.sel = sel;
    it.val = val;
    it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: compare items that fall due in this cycle
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].due == cyc) begin
        check(expQ[i].req, $sformatf("sel%0d", expQ[i].sel), pick(expQ[i].sel), expQ[i].val);
        expQ.delete(i);
      end
    end
  end

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic writeCfg(bit en, int lvl, bit mode, int presc);
    @(negedge clk);
    cfgWr    = 1'b1;
    cfgEn    = en;
    cfgLevel = 2'(lvl);
    cfgMode  = mode;
    cfgPresc = 4'(presc);
  endtask

  task automatic endWrite();
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic measureHalf(int expLen, string req);
    logic prev;
    int   len;
    int   guard;
    @(negedge clk);
    prev  = convClk;
    guard = 0;
    while (convClk == prev && guard < 64) begin @(negedge clk); guard++; end
    prev = convClk;
    len  = 0;
    while (convClk == prev && len < 64) begin @(negedge clk); len++; end
    check(req, "convClk half period", len, expLen);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "convEn", int'(convEn), 0);
    check("R1", "shutBusy", int'(shutBusy), 0);
    check("R1", "rdEnable", int'(rdEnable), 0);
    check("R1", "ovcFlag", int'(ovcFlag), 0);
    check("R1", "pwrDownErr", int'(pwrDownErr), 0);
    check("R1", "convLevel", int'(convLevel), 0);
    check("R1", "convMode", int'(convMode), 0);
    measureHalf(1, "R1");

    // R3: enable with no card present
    writeCfg(1'b1, 2, 1'b1, 0);
    expectAt(S_RDEN, 1, 1, "R3");
    expectAt(S_EN, 0, 2, "R3");
    expectAt(S_EN, 0, 8, "R3");
    expectAt(S_LVL, 2, 2, "R9");
    expectAt(S_MODE, 1, 2, "R9");
    endWrite();
    drain();

    // R4: short glitch is ignored
    @(negedge clk);
    cardRaw = 1'b1;
    for (int k = 1; k <= DEB_LEN + 6; k++) expectAt(S_EN, 0, k, "R4");
    repeat (DEB_LEN - 1) @(negedge clk);
    cardRaw = 1'b0;
    drain();

    // R4/R2: steady card makes presence valid, converter starts
    @(negedge clk);
    cardRaw = 1'b1;
    expectAt(S_EN, 0, DEB_LEN + 2, "R4");
    expectAt(S_EN, 1, DEB_LEN + 3, "R4");
    drain();

    // R9: level write while on is held off the outputs
    writeCfg(1'b1, 1, 1'b0, 0);
    expectAt(S_LVL, 2, 2, "R9");
    expectAt(S_MODE, 1, 5, "R9");
    expectAt(S_EN, 1, 5, "R2");
    endWrite();
    drain();

    // R11: power-down request while on
    @(negedge clk);
    pwrDownReq = 1'b1;
    expectAt(S_PDE, 1, 1, "R11");
    @(negedge clk);
    pwrDownReq = 1'b0;
    expectAt(S_PDE, 0, 1, "R11");
    drain();

    // R5: card removal triggers discharge
    @(negedge clk);
    cardRaw = 1'b0;
    expectAt(S_EN, 1, DEB_LEN + 2, "R5");
    expectAt(S_EN, 0, DEB_LEN + 3, "R5");
    expectAt(S_BUSY, 1, DEB_LEN + 3, "R5");
    expectAt(S_RDEN, 0, DEB_LEN + 3, "R5");
    expectAt(S_BUSY, 1, DEB_LEN + 2 + DIS_LEN, "R5");
    expectAt(S_BUSY, 0, DEB_LEN + 3 + DIS_LEN, "R5");
    expectAt(S_EN, 0, DEB_LEN + 3 + DIS_LEN, "R5");
    expectAt(S_LVL, 3, DEB_LEN + 4 + DIS_LEN, "R9");
    repeat (DEB_LEN + 4) @(negedge clk);
    // R7: write during discharge is ignored
    cfgWr = 1'b1; cfgEn = 1'b1; cfgLevel = 2'd3; cfgMode = 1'b0; cfgPresc = 4'd0;
    expectAt(S_RDEN, 0, 1, "R7");
    expectAt(S_LVL, 2, 2, "R9");
    endWrite();
    drain();

    // R11: request while off is not flagged
    @(negedge clk);
    pwrDownReq = 1'b1;
    expectAt(S_PDE, 0, 1, "R11");
    @(negedge clk);
    pwrDownReq = 1'b0;

    // R7: card back, enable bit cleared, converter stays off
    cardRaw = 1'b1;
    for (int k = 2; k <= DEB_LEN + 8; k += 2) expectAt(S_EN, 0, k, "R7");
    drain();
    writeCfg(1'b1, 3, 1'b0, 0);
    expectAt(S_EN, 0, 1, "R2");
    expectAt(S_EN, 1, 2, "R2");
    endWrite();
    drain();

    // R6: overcurrent pulse
    @(negedge clk);
    overCurr = 1'b1;
    expectAt(S_EN, 1, 1, "R6");
    expectAt(S_EN, 0, 2, "R6");
    expectAt(S_BUSY, 1, 2, "R6");
    expectAt(S_OVC, 1, 2, "R6");
    expectAt(S_RDEN, 0, 2, "R6");
    expectAt(S_OVC, 1, DIS_LEN + 4, "R6");
    expectAt(S_EN, 0, DIS_LEN + 4, "R7");
    @(negedge clk);
    overCurr = 1'b0;
    drain();
    writeCfg(1'b1, 3, 1'b0, 0);
    expectAt(S_OVC, 0, 1, "R6");
    expectAt(S_EN, 1, 2, "R2");
    endWrite();
    drain();

    // R8: software turn-off
    writeCfg(1'b0, 3, 1'b0, 0);
    expectAt(S_RDEN, 0, 1, "R8");
    expectAt(S_EN, 1, 1, "R8");
    expectAt(S_EN, 0, 2, "R8");
    expectAt(S_BUSY, 1, 2, "R8");
    expectAt(S_OVC, 0, 2, "R8");
    expectAt(S_BUSY, 1, DIS_LEN + 1, "R8");
    expectAt(S_BUSY, 0, DIS_LEN + 2, "R8");
    endWrite();
    drain();

    // R10: prescaler settings
    writeCfg(1'b0, 3, 1'b0, 3);
    endWrite();
    repeat (10) @(negedge clk);
    measureHalf(4, "R10");
    measureHalf(4, "R10");
    writeCfg(1'b0, 3, 1'b0, 15);
    endWrite();
    repeat (40) @(negedge clk);
    measureHalf(16, "R10");
    writeCfg(1'b0, 3, 1'b0, 0);
    endWrite();
    repeat (20) @(negedge clk);
    measureHalf(1, "R10");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule